// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block divides a fast input clock by a programmable ratio N and produces one single-cycle pulse per N input cycles. The pulse feeds the feedback side of a phase comparator in a frequency synthesizer. Inside it, a prescaler switches its modulus between 9 and 8. A swallow counter holds the count of 9-cycle groups, and a program counter holds the total number of prescaler cycles per output period. Each period is therefore A groups of 9 cycles followed by M−A groups of 8, and N = 8·M + A.

The divider word packs A into its three low bits and M into the ten bits above them. As a result, the numeric value of the word is N itself, and software can write the wanted ratio directly. A companion reference divider brings the crystal clock down by a 10-bit ratio R. The synthesized frequency is then N/R times the crystal frequency.

A new divider or reference setting is taken up only at the end of the current output period, so no period is ever cut short. An M field below 7 is treated as 7. A reference ratio of 0 is treated as 1 (bypass). Each divider has its own clock and synchronous active-low reset.

Top module: `pswal_freq_div`

## Requirements
- R1: Within each feedback period the prescaler runs A cycles of 9 input clocks first and then M−A cycles of 8, where A = div_word[2:0] and M = div_word[12:3].
- R2: fb_pulse is high for exactly one fb_clk cycle, once every N = 8·M + A fb_clk cycles.
- R3: Because A sits in div_word[2:0] and M in div_word[12:3], writing any value from 56 to 8191 to div_word gives a period of exactly that many cycles.
- R4: An M field below 7 is used as 7, so the period becomes 56 + A.
- R5: A change of div_word or ref_word during a period does not alter that period. The new ratio applies from the period that starts after the next output pulse.
- R6: ref_pulse is high for one ref_clk cycle once every R ref_clk cycles, with R = ref_word[9:0] for R from 2 to 1023.
- R7: A ref_word of 0 or 1 makes ref_pulse high on every ref_clk cycle.
- R8: While a reset input is low, and in the cycle after the first edge at which it is sampled high, the related pulse output is low. The first period is counted from that edge, so the first pulse falls in the N-th (or R-th) cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Fast input clock to be divided |
| fb_rst_n | input | 1 | Synchronous active-low reset of the feedback divider |
| div_word | input | 13 | Divider word: A in [2:0], M in [12:3] |
| fb_pulse | output | 1 | One-cycle pulse per N fb_clk cycles |
| ref_clk | input | 1 | Crystal-side clock |
| ref_rst_n | input | 1 | Synchronous active-low reset of the reference divider |
| ref_word | input | 10 | Reference ratio R (0 acts as 1) |
| ref_pulse | output | 1 | One-cycle pulse per R ref_clk cycles |

## Verification
The assertions check several properties on every cycle:
- the prescaler never ticks on two cycles in a row;
- the swallow count never exceeds the remaining program count;
- a reloaded program count is never below 7;
- a feedback pulse never lasts two cycles;
- a reference ratio of one keeps the reference pulse high.

Some behaviour only the bench's scenarios can show. That includes the exact period of 8·M + A, the clamping of small M values and the deferral of mid-period setting changes. It also includes the timing of the first pulse after reset. The bench shows these by comparing both pulse outputs against a counting model on every clock and by timing the gap between feedback pulses.

// File: rtl/pswal_pkg.sv
// Shared sizing constants for the pulse-swallow divider.
package pswal_pkg;
    localparam int unsigned PRE_MOD = 8;   // low prescaler modulus; high is PRE_MOD+1
    localparam int unsigned A_W     = 3;   // swallow field width
    localparam int unsigned M_W     = 10;  // program field width
    localparam int unsigned R_W     = 10;  // reference ratio width
    localparam int unsigned M_MIN   = 7;   // smallest program count accepted
endpackage

// File: rtl/pswal_prescaler.sv
// Dual-modulus prescaler. It counts PRE_MOD+1 or PRE_MOD input cycles
// per tick. The modulus for the next group is chosen by mod_hi_next,
// which is sampled whenever a group starts (on a tick or a restart).
// Assumes the controller holds mod_hi_next valid at every edge.
module pswal_prescaler #(
    parameter int unsigned PRE_MOD = pswal_pkg::PRE_MOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mod_hi_next,
    output logic tick
);
    localparam int unsigned PC_W = $clog2(PRE_MOD + 1);
    localparam logic [PC_W-1:0] LD_HI = PC_W'(PRE_MOD);
    localparam logic [PC_W-1:0] LD_LO = PC_W'(PRE_MOD - 1);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] ld_val;

    // Pick the start value for the next prescaler group.
    always_comb ld_val = mod_hi_next ? LD_HI : LD_LO;

    // Count down within a group and reload at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc <= ld_val;
        else if (restart || tick)   pc <= ld_val;
        else                        pc <= pc - PC_W'(1);
    end

    // Last input cycle of the current group.
    always_comb tick = (pc == '0);

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R1
endmodule

// File: rtl/pswal_swallow_ctrl.sv
// Swallow/program counter pair. It counts prescaler ticks, picks the
// prescaler modulus for each group and flags the last input cycle of
// every output period. The divider word is sampled only at period
// boundaries and while held in reset. Assumes 2**A_W-1 <= M_MIN, so the
// swallow count never exceeds the program count.
module pswal_swallow_ctrl #(
    parameter int unsigned A_W   = pswal_pkg::A_W,
    parameter int unsigned M_W   = pswal_pkg::M_W,
    parameter int unsigned M_MIN = pswal_pkg::M_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W+M_W-1:0] div_word,
    input  logic             tick,
    output logic             restart,
    output logic             mod_hi_next,
    output logic             period_end
);
    logic [A_W-1:0] a_new;
    logic [M_W-1:0] m_raw;
    logic [M_W-1:0] m_new;
    logic [M_W-1:0] m_left;
    logic [A_W-1:0] sw_left;
    logic           live;
    logic           load_now;

    // Split the word and raise a too-small program count to the floor.
    always_comb begin
        a_new = div_word[A_W-1:0];
        m_raw = div_word[A_W+M_W-1:A_W];
        m_new = (m_raw < M_W'(M_MIN)) ? M_W'(M_MIN) : m_raw;
    end

    // Restart is held for the first edge after reset so counting starts there.
    always_comb restart = !rst_n || !live;

    // Last input cycle of the final prescaler group of a period.
    always_comb period_end = live && tick && (m_left == M_W'(1));

    // A reload happens on restart or at the end of a period.
    always_comb load_now = restart || period_end;

    // Modulus for the group that starts at the coming edge.
    always_comb begin
        if (load_now)  mod_hi_next = (a_new != '0);
        else if (tick) mod_hi_next = (sw_left > A_W'(1));
        else           mod_hi_next = (sw_left != '0);
    end

    // Track the live flag and count prescaler groups down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live    <= 1'b0;
            m_left  <= m_new;
            sw_left <= a_new;
        end else if (load_now) begin
            live    <= 1'b1;
            m_left  <= m_new;
            sw_left <= a_new;
        end else if (tick) begin
            m_left  <= m_left - M_W'(1);
            if (sw_left != '0) sw_left <= sw_left - A_W'(1);
        end
    end

    AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ({{M_W{1'b0}}, sw_left} <= {{A_W{1'b0}}, m_left}));  // R1
    AST_M_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (m_left >= M_W'(M_MIN)));  // R4
    AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end);  // R2
endmodule

// File: rtl/pswal_ref_div.sv
// Reference divider. It gives one pulse per R input cycles, where a ratio
// of 0 is treated as 1 (bypass). A new ratio is taken at the end of a
// period. Counting starts at the first edge after reset is released.
module pswal_ref_div #(
    parameter int unsigned R_W = pswal_pkg::R_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] ref_word,
    output logic           ref_pulse
);
    logic [R_W-1:0] r_eff;
    logic [R_W-1:0] ld_val;
    logic [R_W-1:0] rc;
    logic           live;

    // Effective ratio with the zero-means-bypass rule.
    always_comb begin
        r_eff  = (ref_word == '0) ? R_W'(1) : ref_word;
        ld_val = r_eff - R_W'(1);
    end

    // Down-counter with reload at the last cycle of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            rc   <= ld_val;
        end else if (!live) begin
            live <= 1'b1;
            rc   <= ld_val;
        end else if (rc == '0) begin
            rc   <= ld_val;
        end else begin
            rc   <= rc - R_W'(1);
        end
    end

    // Pulse on the last cycle of each period once counting is live.
    always_comb ref_pulse = live && (rc == '0);

    AST_REF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && r_eff == R_W'(1)) |=> ref_pulse);  // R7
endmodule

// File: rtl/pswal_freq_div.sv
// Top of the synthesizer divider pair. The feedback path is an 8/9
// pulse-swallow divider with ratio 8*M + A, taken from a word that holds
// A in its low bits and M above them. The reference path is a plain
// R divider. The two paths have independent clocks and synchronous
// active-low resets.
module pswal_freq_div #(
    parameter int unsigned PRE_MOD = pswal_pkg::PRE_MOD,
    parameter int unsigned A_W     = pswal_pkg::A_W,
    parameter int unsigned M_W     = pswal_pkg::M_W,
    parameter int unsigned R_W     = pswal_pkg::R_W,
    parameter int unsigned M_MIN   = pswal_pkg::M_MIN
) (
    input  logic               fb_clk,
    input  logic               fb_rst_n,
    input  logic [A_W+M_W-1:0] div_word,
    output logic               fb_pulse,
    input  logic               ref_clk,
    input  logic               ref_rst_n,
    input  logic [R_W-1:0]     ref_word,
    output logic               ref_pulse
);
    logic pre_tick;
    logic pre_restart;
    logic pre_mod_hi;

    pswal_prescaler #(.PRE_MOD(PRE_MOD)) u_pre (
        .clk         (fb_clk),
        .rst_n       (fb_rst_n),
        .restart     (pre_restart),
        .mod_hi_next (pre_mod_hi),
        .tick        (pre_tick)
    );

    pswal_swallow_ctrl #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_ctrl (
        .clk         (fb_clk),
        .rst_n       (fb_rst_n),
        .div_word    (div_word),
        .tick        (pre_tick),
        .restart     (pre_restart),
        .mod_hi_next (pre_mod_hi),
        .period_end  (fb_pulse)
    );

    pswal_ref_div #(.R_W(R_W)) u_ref (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .ref_word  (ref_word),
        .ref_pulse (ref_pulse)
    );
endmodule

// File: tb/pswal_freq_div_tb.sv
// Bench: a counting model of both dividers, compared on every clock,
// plus a measurement of the gap between feedback pulses.
module pswal_freq_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] div_word = 13'd56;
    logic [9:0]  ref_word = 10'd0;
    logic        fb_pulse, ref_pulse;

    int n_chk = 0, n_err = 0;
    int fb_cnt = 0, fb_cur = 56, rf_cnt = 0, rf_cur = 1;
    bit m_live = 0, started = 0, have_last = 0, done = 0;
    int cyc = 0, last_pulse = 0;
    logic [12:0] start_word = 13'd56;

    always #5 clk = ~clk;

    pswal_freq_div u_dut (
        .fb_clk(clk), .fb_rst_n(rst_n), .div_word(div_word), .fb_pulse(fb_pulse),
        .ref_clk(clk), .ref_rst_n(rst_n), .ref_word(ref_word), .ref_pulse(ref_pulse)
    );

    function automatic int n_of(logic [12:0] w);
        int m = int'(w[12:3]);
        if (m < 7) m = 7;
        return m * 8 + int'(w[2:0]);
    endfunction

    function automatic int r_of(logic [9:0] w);
        return (w == 10'd0) ? 1 : int'(w);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n || !m_live) begin
            fb_cnt = 0; fb_cur = n_of(div_word); start_word = div_word;
            rf_cnt = 0; rf_cur = r_of(ref_word);
        end else begin
            if (fb_cnt == fb_cur - 1) begin
                fb_cnt = 0; fb_cur = n_of(div_word); start_word = div_word;
            end else fb_cnt++;
            if (rf_cnt == rf_cur - 1) begin
                rf_cnt = 0; rf_cur = r_of(ref_word);
            end else rf_cnt++;
        end
        m_live = rst_n;
    end

    // Compare outputs away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit e_fb, e_rf;
            string tag;
            cyc++;
            e_fb = m_live && (fb_cnt == fb_cur - 1);
            e_rf = m_live && (rf_cnt == rf_cur - 1);
            chk(fb_pulse === e_fb, m_live ? "R2 fb_pulse" : "R8 fb_pulse in reset",
                int'(fb_pulse), int'(e_fb));
            chk(ref_pulse === e_rf, !m_live ? "R8 ref_pulse in reset" :
                (rf_cur == 1 ? "R7 ref bypass" : "R6 ref_pulse"), int'(ref_pulse), int'(e_rf));
            if (!rst_n) have_last = 0;
            else if (fb_pulse === 1'b1) begin
                if (have_last) begin
                    if (div_word != start_word)       tag = "R5 period kept after mid-period change";
                    else if (start_word[12:3] < 7)    tag = "R4 clamped period";
                    else if (start_word[2:0] != 0)    tag = "R1 swallow period";
                    else                              tag = "R3 period equals word";
                    chk((cyc - last_pulse) == fb_cur, tag, cyc - last_pulse, fb_cur);
                end
                have_last = 1; last_pulse = cyc;
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        run(5);                              // R8: outputs low in reset
        rst_n = 1'b1; run(200);              // N=56, R=0 bypass (R7)
        div_word = 13'd63; run(200);         // A=7, M=7 (R1, R3)
        ref_word = 10'd1; run(50);           // R7
        ref_word = 10'd2; div_word = 13'd5;  run(250);  // M=0 -> 61 (R4)
        div_word = 13'd19; ref_word = 10'd3; run(250);  // M=2,A=3 -> 59
        for (int i = 0; i < 20; i++) begin   // random legal settings (R5, R6)
            div_word = 13'(56 + ($urandom % 650));
            ref_word = 10'($urandom % 40);
            run(100 + ($urandom % 1400));
        end
        ref_word = 10'd1023; div_word = 13'd8191; run(17000);  // max ratios
        div_word = 13'd56; run(300);
        rst_n = 1'b0; run(3);                // R8: reset mid-run
        ref_word = 10'd5; div_word = 13'd100;
        rst_n = 1'b1; run(400);
        finish_up();
    end
endmodule